// File: doc/BRIEF.md
# Interleaved Multichannel Sample Packer

The packer samples a set of digital input lines whenever a sample strobe is high. It builds, for every channel, a word of sixteen consecutive samples. Once the sixteenth strobe of a group arrives, the finished group moves to a hold bank. The hold bank then drains as a byte stream with a valid/ready handshake. Only the channels selected by the channel mask send data. Each selected channel sends its word as two adjacent bytes, and the channels go out from the lowest index upward. After the last selected channel, the next group starts again at the lowest selected channel.

Capture continues while the hold bank drains, so a steady strobe loses no samples if the consumer keeps up. If a new group completes while the previous group still has bytes waiting, the new group is dropped and a sticky overflow flag is raised. Any change of the mask discards the pending output and restarts the sample count.

Top module: `chan_word_packer`

## Requirements
- R1: While rst_ni is low, valid_o and ovf_o are 0.
- R2: Bit k of a channel word equals that channel's level at the k-th strobe of the group (k = 0 is the earliest strobe, 1 = high, 0 = low).
- R3: Each channel word is sent as two adjacent bytes: bits 7:0 first, then bits 15:8. No other channel's byte comes between them.
- R4: Within a group, words go out for the enabled channels in ascending index order. The next group starts again at the lowest enabled channel.
- R5: A channel whose mask bit is 0 sends no bytes. With the mask at 0, valid_o stays 0. Each group sends exactly 2 × (number of set mask bits) bytes.
- R6: While one group drains, the next group is captured. If the previous group's last byte is accepted in the same cycle that the next group completes, the new group is loaded without loss.
- R7: A group that completes while the previous group still has bytes pending (other than a last byte accepted in that cycle) is dropped. In that case ovf_o goes to 1 and stays 1 until reset.
- R8: In any cycle where ch_mask_i differs from its value in the previous cycle, three things happen. Pending output is discarded, so valid_o is 0 in the next cycle. The sample count restarts, and the strobe in that cycle is ignored. ovf_o is unchanged.
- R9: While valid_o is 1 and ready_i is 0, valid_o and byte_o hold their values in the next cycle (unless R8 applies).
- R10: valid_o rises in the cycle after the strobe that completes a group, when that group is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch_i | input | NUM_CH | Raw channel levels |
| smp_en_i | input | 1 | Sample strobe |
| ch_mask_i | input | NUM_CH | Channel enable mask, bit c enables channel c |
| byte_o | output | 8 | Output byte |
| valid_o | output | 1 | Output byte valid |
| ready_i | input | 1 | Consumer accepts byte |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The embedded assertions check on every cycle that the output is stable during a stall and that the channel being sent has its mask bit set. They also check that an all-zero mask leaves nothing pending, that overflow is sticky and rises only when a group completes, and that a mask change resets the sample count. Bit order, byte order, channel interleave, skipping of disabled channels and the exact byte count per group can only be shown by the bench's reference model. The same applies to the boundary where a last byte is accepted while a new group completes. The bench covers these with masks of 3, 6, 9 and 16 channels, under varied strobe rates and back-pressure.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cwp_capture.sv
module cwp_capture #(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        ch_i,
  input  logic                     smp_en_i,
  input  logic [NUM_CH-1:0]        ch_mask_i,
  output logic [NUM_CH-1:0]        mask_o,
  output logic                     mask_chg_o,
  output logic                     grp_done_o,
  output logic [NUM_CH*WORD_W-1:0] grp_word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);

  logic [NUM_CH-1:0] mask_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              shift_en;

  assign mask_chg_o = (ch_mask_i != mask_q);
  assign mask_o     = mask_q;
  assign shift_en   = smp_en_i && !mask_chg_o;
  assign grp_done_o = shift_en && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      mask_q <= ch_mask_i;
      if (mask_chg_o)    cnt_q <= '0;
      else if (shift_en) cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end
  end

  // newest sample enters at the top, so after a full group the earliest sits in bit 0
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [WORD_W-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= '0;
      else if (shift_en) sh_q <= {ch_i[c], sh_q[WORD_W-1:1]};
    end
    assign grp_word_o[c*WORD_W +: WORD_W] = {ch_i[c], sh_q[WORD_W-1:1]};
  end

  a_r8_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |=> (cnt_q == '0));
endmodule

// File: rtl/cwp_serializer.sv
module cwp_serializer
  import cwp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        mask_i,
  input  logic                     mask_chg_i,
  input  logic                     grp_done_i,
  input  logic [NUM_CH*WORD_W-1:0] grp_word_i,
  output byte_t                    byte_o,
  output logic                     valid_o,
  input  logic                     ready_i,
  output logic                     ovf_o
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NBYTES - 1);

  logic [NUM_CH*WORD_W-1:0] hold_q;
  logic                     full_q, ovf_q;
  logic [CH_W-1:0]          ch_q, nxt_ch, first_ch;
  logic [SEL_W-1:0]         sel_q;
  logic                     nxt_found, fire, last_byte, free, load, drop;
  logic [WORD_W-1:0]        cur_word;

  always_comb begin
    nxt_found = 1'b0;
    nxt_ch    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i] && (i > int'(ch_q))) begin
        nxt_found = 1'b1;
        nxt_ch    = CH_W'(i);
      end
    end
  end

  always_comb begin
    first_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) first_ch = CH_W'(i);
    end
  end

  assign fire      = full_q && ready_i;
  assign last_byte = (sel_q == SEL_MAX);
  assign free      = !full_q || (fire && last_byte && !nxt_found);
  assign load      = grp_done_i && !mask_chg_i && free && (|mask_i);
  assign drop      = grp_done_i && !mask_chg_i && !free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
      ch_q   <= '0;
      sel_q  <= '0;
    end else if (mask_chg_i) begin
      full_q <= 1'b0;
      ch_q   <= '0;
      sel_q  <= '0;
    end else if (load) begin
      hold_q <= grp_word_i;
      full_q <= 1'b1;
      ch_q   <= first_ch;
      sel_q  <= '0;
    end else if (fire) begin
      if (!last_byte) begin
        sel_q <= sel_q + 1'b1;
      end else if (nxt_found) begin
        ch_q  <= nxt_ch;
        sel_q <= '0;
      end else begin
        full_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  assign cur_word = hold_q[int'(ch_q)*WORD_W +: WORD_W];
  assign byte_o   = cur_word[int'(sel_q)*BYTE_W +: BYTE_W];
  assign valid_o  = full_q;
  assign ovf_o    = ovf_q;

  a_r9_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !mask_chg_i) |=> (valid_o && $stable(byte_o)));
  a_r4_ch_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> mask_i[ch_q]);
  a_r5_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !valid_o);
  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r7_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(grp_done_i));
  a_r10_load_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_done_i && !mask_chg_i && !valid_o && (mask_i != '0)) |=> valid_o);
endmodule

// File: rtl/chan_word_packer.sv
module chan_word_packer
  import cwp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ch_i,
  input  logic              smp_en_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              ovf_o
);
  logic [NUM_CH-1:0]        mask_q;
  logic                     mask_chg, grp_done;
  logic [NUM_CH*WORD_W-1:0] grp_word;
  byte_t                    ser_byte;

  cwp_capture #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ch_i       (ch_i),
    .smp_en_i   (smp_en_i),
    .ch_mask_i  (ch_mask_i),
    .mask_o     (mask_q),
    .mask_chg_o (mask_chg),
    .grp_done_o (grp_done),
    .grp_word_o (grp_word)
  );

  cwp_serializer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_i     (mask_q),
    .mask_chg_i (mask_chg),
    .grp_done_i (grp_done),
    .grp_word_i (grp_word),
    .byte_o     (ser_byte),
    .valid_o    (valid_o),
    .ready_i    (ready_i),
    .ovf_o      (ovf_o)
  );

  assign byte_o = ser_byte;
endmodule

// File: tb/chan_word_packer_bench.sv
module chan_word_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ch = '0;
  logic        smp_en = 1'b0;
  logic [15:0] mask = '0;
  logic [7:0]  byte_w;
  logic        valid_w;
  logic        ready = 1'b0;
  logic        ovf_w;

  int n_tests = 0;
  int n_fail  = 0;
  int n_bytes = 0;
  string cur_req = "R1";

  logic [7:0]  bq[$];
  logic [15:0] smp[$];
  logic [15:0] m_mask = '0;
  logic        m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_word_packer u_chan_word_packer (
    .clk_i(clk), .rst_ni(rst_n), .ch_i(ch), .smp_en_i(smp_en),
    .ch_mask_i(mask), .byte_o(byte_w), .valid_o(valid_w),
    .ready_i(ready), .ovf_o(ovf_w)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic build_group();
    for (int c = 0; c < 16; c++) begin
      if (m_mask[c]) begin
        logic [15:0] w;
        for (int k = 0; k < 16; k++) w[k] = smp[k][c];
        bq.push_back(w[7:0]);
        bq.push_back(w[15:8]);
      end
    end
  endtask

  task automatic step(input logic en, input logic [15:0] chv, input logic [15:0] msk, input logic rdy);
    logic fire;
    smp_en = en; ch = chv; mask = msk; ready = rdy;
    #1;
    begin
      int ev, eb;
      ev = (bq.size() > 0) ? 1 : 0;
      eb = ev ? int'(bq[0]) : 0;
      n_tests++;
      if (valid_w !== ev[0] || ovf_w !== m_ovf || (ev != 0 && byte_w !== eb[7:0])) begin
        n_fail++;
        $display("FAIL %s stream actual v=%0d b=%0h o=%0d expected v=%0d b=%0h o=%0d at %0t",
                 cur_req, valid_w, byte_w, ovf_w, ev, eb, m_ovf, $time);
      end
    end
    fire = (bq.size() > 0) && rdy;
    if (valid_w && rdy) n_bytes++;
    if (msk != m_mask) begin
      bq.delete();
      smp.delete();
      m_mask = msk;
    end else begin
      if (fire) void'(bq.pop_front());
      if (en) begin
        smp.push_back(chv);
        if (smp.size() == 16) begin
          if (bq.size() == 0) build_group();
          else m_ovf = 1'b1;
          smp.delete();
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk("R1", int'(valid_w), 0, "valid in reset");
    chk("R1", int'(ovf_w), 0, "ovf in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R10: 3 channels, strobe every cycle, always ready
    cur_req = "R2/R3/R4/R10";
    n_bytes = 0;
    for (int i = 0; i < 16 * 4 + 1; i++) step(1'b1, 16'(i * 16'h9e37 ^ (i << 3)), 16'h0007, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, '0, 16'h0007, 1'b1);
    chk("R5", n_bytes, 4 * 6, "bytes for 4 groups of 3 channels");

    // R9: 6 channels, strobe every other cycle, random back-pressure
    cur_req = "R9";
    for (int i = 0; i < 16 * 2 * 5; i++)
      step(i[0], 16'($urandom), 16'h003F, ($urandom % 3) != 0);
    for (int i = 0; i < 40; i++) step(1'b0, '0, 16'h003F, 1'b1);
    chk("R7", int'(ovf_w), 0, "no overflow with 6 channels");

    // R4 R5: 9 channels, strobe every other cycle
    cur_req = "R4/R5";
    step(1'b0, '0, 16'h01FF, 1'b1);
    n_bytes = 0;
    for (int i = 0; i < 16 * 2 * 3; i++) step(i[0], 16'($urandom), 16'h01FF, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, '0, 16'h01FF, 1'b1);
    chk("R5", n_bytes, 3 * 18, "bytes for 3 groups of 9 channels");

    // R6: 16 channels, 32 bytes per 32-cycle group, last byte meets next group
    cur_req = "R6";
    step(1'b0, '0, 16'hFFFF, 1'b1);
    n_bytes = 0;
    for (int i = 0; i < 16 * 2 * 4; i++) step(i[0], 16'($urandom), 16'hFFFF, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, '0, 16'hFFFF, 1'b1);
    chk("R6", n_bytes, 4 * 32, "bytes without loss at 16 channels");
    chk("R6", int'(ovf_w), 0, "no overflow at exact drain rate");

    // R7: stall while two groups complete
    cur_req = "R7";
    for (int i = 0; i < 32; i++) step(1'b1, 16'($urandom), 16'hFFFF, 1'b0);
    chk("R7", int'(ovf_w), 1, "overflow set after stall");
    for (int i = 0; i < 10; i++) step(1'b0, '0, 16'hFFFF, 1'b1);
    chk("R7", int'(ovf_w), 1, "overflow sticky");

    // R8: mask change mid-drain and mid-capture
    cur_req = "R8";
    for (int i = 0; i < 8; i++) step(1'b1, 16'($urandom), 16'hFFFF, 1'b1);
    step(1'b1, 16'hFFFF, 16'h0007, 1'b1);
    chk("R8", int'(valid_w), 0, "valid dropped after mask change");
    chk("R8", int'(ovf_w), 1, "overflow kept over mask change");
    for (int i = 0; i < 16 * 3; i++) step(1'b1, 16'($urandom), 16'h0007, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, '0, 16'h0007, 1'b1);

    // R5: zero mask sends nothing
    cur_req = "R5";
    n_bytes = 0;
    for (int i = 0; i < 40; i++) step(1'b1, 16'($urandom), 16'h0000, 1'b1);
    chk("R5", n_bytes, 0, "no bytes with zero mask");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule